// File: doc/BRIEF.md
# Weighted Early Drop Decider

This block gives an admission verdict for each packet that arrives at an egress port which keeps six counted priority queues, P2 up to P7. Each request brings the packet's destination queue and its drop class (high-drop or low-drop). Alongside it the block reads the live byte count of every counted queue, a set of per-queue thresholds, three drop percentages and the active scheduling discipline. From the byte counts it forms one aggregate load figure. That figure puts the packet in one of four congestion levels (none, or levels one to three). A pseudo-random draw then turns the percentage for that level and drop class into a drop or accept decision.

The decision is registered and comes out one clock after the request, together with the level that was applied. Counting the queue bytes, scheduling the queues and actually discarding the packet all happen outside this block.

Top module: `wred_drop_decider`

## Requirements
- R1: With `sched_delay_mode`=1 the load is 16·P7 + 16·P6 + 8·P5 + 4·P4 + 2·P3 + P2, where Pn is the byte count in lane n-2 of `q_bytes` (lane 0 = P2, lane 5 = P7).
- R2: With `sched_delay_mode`=0 the load is the plain sum P2 + P3 + P4 + P5 + P6 + P7.
- R3: The level comes from the load compared with LVL1_UNITS, LVL2_UNITS and LVL3_UNITS, each scaled by 2^UNIT_SHIFT bytes, using greater-or-equal. The highest level whose condition holds is the one applied. `verdict_level` encodes none=0, one=1, two=2, three=3.
- R4: When `req_dest` is 2..7 and that queue's byte count is at least its `q_thr` lane times 2^UNIT_SHIFT, the level is at least one. A destination of 0 or 1 (P0, P1) never raises the level.
- R5: At level one, a high-drop packet (`req_hi_drop`=1) is dropped according to `pct_x`, and a low-drop packet is never dropped.
- R6: At level two, high-drop packets are dropped according to `pct_y` and low-drop packets according to `pct_z`.
- R7: At level three every packet is dropped, whatever its drop class and whatever the percentages.
- R8: A packet is dropped at a percentage p when (16-bit LFSR value mod 100) < p. A value of 0 never drops and any value of 100 or more always drops. The LFSR advances every cycle, and over many packets the drop rate follows p. At level none nothing is dropped.
- R9: `verdict_valid` is high exactly in the cycle after a cycle in which `req_valid` was high. When it is low, `verdict_drop` and `verdict_level` are 0.
- R10: The load is computed at full width (byte count width plus 6 bits), so queue counts at their maximum still land at level three in both modes.
- R11: During reset `verdict_valid`, `verdict_drop` and `verdict_level` are 0.
- R12: The LFSR state never becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Admission request present |
| req_dest | input | 3 | Destination queue number 0..7 |
| req_hi_drop | input | 1 | 1 = high-drop class, 0 = low-drop class |
| sched_delay_mode | input | 1 | 1 = delay-bound weights, 0 = equal weights |
| q_bytes | input | 6*CNT_W | Byte counts, lane i holds queue P(i+2) |
| q_thr | input | 6*THR_W | Per-queue thresholds in 2^UNIT_SHIFT-byte units, same lanes |
| pct_x | input | 7 | High-drop percentage at level one |
| pct_y | input | 7 | High-drop percentage at level two |
| pct_z | input | 7 | Low-drop percentage at level two |
| verdict_valid | output | 1 | Verdict present |
| verdict_drop | output | 1 | 1 = discard the packet |
| verdict_level | output | 2 | Level applied to the packet |

## Verification
The bench builds the block with CNT_W=14, THR_W=8 and UNIT_SHIFT=4. The three load levels then sit at 3840, 4480 and 5120 bytes. Because the counts are small, the bench can place the load exactly on each boundary and one byte below it in both scheduling modes, and can drive every queue to its largest count to test for overflow. Per-queue thresholds are reachable in the same small range. The percentages are set to 0 and 100 for checks that must always give the same result, and a run of 400 packets at 50% checks the drop rate.

// File: rtl/wred_pkg.sv
package wred_pkg;
  localparam int NUM_Q = 6;

  typedef enum logic [1:0] {
    LVL_NONE  = 2'd0,
    LVL_ONE   = 2'd1,
    LVL_TWO   = 2'd2,
    LVL_THREE = 2'd3
  } wred_lvl_e;

  // weight exponent of lane i (queue P(i+2)) under delay-bound scheduling
  function automatic int delay_weight_shift(input int lane);
    case (lane)
      0: delay_weight_shift = 0;
      1: delay_weight_shift = 1;
      2: delay_weight_shift = 2;
      3: delay_weight_shift = 3;
      default: delay_weight_shift = 4;
    endcase
  endfunction
endpackage

// File: rtl/wred_load_sum.sv
module wred_load_sum
  import wred_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int SUM_W = CNT_W + 6
) (
  input  logic [NUM_Q*CNT_W-1:0] q_bytes,
  input  logic                   delay_mode,
  output logic [SUM_W-1:0]       load
);
  logic [SUM_W-1:0] term [NUM_Q];

  for (genvar g = 0; g < NUM_Q; g++) begin : g_term
    logic [SUM_W-1:0] cnt_ext;
    assign cnt_ext = SUM_W'(q_bytes[g*CNT_W +: CNT_W]);
    assign term[g] = delay_mode ? (cnt_ext << delay_weight_shift(g)) : cnt_ext;
  end

  always_comb begin
    load = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      load = load + term[i];
    end
  end
endmodule

// File: rtl/wred_level_sel.sv
module wred_level_sel
  import wred_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int SUM_W      = CNT_W + 6,
  parameter int THR_W      = 10,
  parameter int UNIT_SHIFT = 10,
  parameter int LVL1_UNITS = 240,
  parameter int LVL2_UNITS = 280,
  parameter int LVL3_UNITS = 320
) (
  input  logic [SUM_W-1:0]       load,
  input  logic [NUM_Q*CNT_W-1:0] q_bytes,
  input  logic [NUM_Q*THR_W-1:0] q_thr,
  input  logic [2:0]             dest,
  output wred_lvl_e              lvl
);
  localparam int CMP_W = (CNT_W > THR_W + UNIT_SHIFT) ? CNT_W : THR_W + UNIT_SHIFT;
  localparam logic [SUM_W-1:0] EDGE1 = SUM_W'(LVL1_UNITS) << UNIT_SHIFT;
  localparam logic [SUM_W-1:0] EDGE2 = SUM_W'(LVL2_UNITS) << UNIT_SHIFT;
  localparam logic [SUM_W-1:0] EDGE3 = SUM_W'(LVL3_UNITS) << UNIT_SHIFT;

  logic [NUM_Q-1:0] over_thr;
  logic             dest_over;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_cmp
    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] thr_ext;
    assign cnt_ext     = CMP_W'(q_bytes[g*CNT_W +: CNT_W]);
    assign thr_ext     = CMP_W'(q_thr[g*THR_W +: THR_W]) << UNIT_SHIFT;
    assign over_thr[g] = (cnt_ext >= thr_ext);
  end

  always_comb begin
    dest_over = 1'b0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (dest == 3'(i + 2)) dest_over = over_thr[i];
    end
  end

  always_comb begin
    if (load >= EDGE3)                  lvl = LVL_THREE;
    else if (load >= EDGE2)             lvl = LVL_TWO;
    else if (load >= EDGE1 || dest_over) lvl = LVL_ONE;
    else                                lvl = LVL_NONE;
  end
endmodule

// File: rtl/wred_lfsr.sv
module wred_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] SEED = W'(16'hACE1),
  parameter logic [W-1:0] MASK = W'(16'hB400)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] state_n;

  always_comb begin
    state_n = (state >> 1) ^ (state[0] ? MASK : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_n;
  end
endmodule

// File: rtl/wred_drop_decider.sv
module wred_drop_decider
  import wred_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int THR_W      = 10,
  parameter int UNIT_SHIFT = 10,
  parameter int LVL1_UNITS = 240,
  parameter int LVL2_UNITS = 280,
  parameter int LVL3_UNITS = 320,
  parameter int LFSR_W     = 16,
  parameter int PCT_W      = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [2:0]             req_dest,
  input  logic                   req_hi_drop,
  input  logic                   sched_delay_mode,
  input  logic [6*CNT_W-1:0]     q_bytes,
  input  logic [6*THR_W-1:0]     q_thr,
  input  logic [PCT_W-1:0]       pct_x,
  input  logic [PCT_W-1:0]       pct_y,
  input  logic [PCT_W-1:0]       pct_z,
  output logic                   verdict_valid,
  output logic                   verdict_drop,
  output logic [1:0]             verdict_level
);
  localparam int SUM_W = CNT_W + 6;

  logic [SUM_W-1:0]  load;
  wred_lvl_e         lvl;
  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] roll;
  logic [PCT_W-1:0]  pct_sel;
  logic              roll_hit;
  logic              vld_n, drop_n;
  logic [1:0]        lvl_n;

  wred_load_sum #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_sum (
    .q_bytes    (q_bytes),
    .delay_mode (sched_delay_mode),
    .load       (load)
  );

  wred_level_sel #(
    .CNT_W(CNT_W), .SUM_W(SUM_W), .THR_W(THR_W), .UNIT_SHIFT(UNIT_SHIFT),
    .LVL1_UNITS(LVL1_UNITS), .LVL2_UNITS(LVL2_UNITS), .LVL3_UNITS(LVL3_UNITS)
  ) u_lvl (
    .load    (load),
    .q_bytes (q_bytes),
    .q_thr   (q_thr),
    .dest    (req_dest),
    .lvl     (lvl)
  );

  wred_lfsr #(.W(LFSR_W)) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_q)
  );

  // draw reduced to 0..99, compared against the active percentage
  assign roll     = lfsr_q % LFSR_W'(100);
  assign roll_hit = (roll < LFSR_W'(pct_sel));

  always_comb begin
    pct_sel = '0;
    drop_n  = 1'b0;
    case (lvl)
      LVL_ONE: begin
        pct_sel = req_hi_drop ? pct_x : '0;
        drop_n  = roll_hit;
      end
      LVL_TWO: begin
        pct_sel = req_hi_drop ? pct_y : pct_z;
        drop_n  = roll_hit;
      end
      LVL_THREE: drop_n = 1'b1;
      default:   drop_n = 1'b0;
    endcase
    vld_n  = req_valid;
    drop_n = drop_n & req_valid;
    lvl_n  = req_valid ? lvl : LVL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      verdict_drop  <= 1'b0;
      verdict_level <= 2'd0;
    end else begin
      verdict_valid <= vld_n;
      verdict_drop  <= drop_n;
      verdict_level <= lvl_n;
    end
  end
endmodule

// File: rtl/wred_drop_checker.sv
module wred_drop_checker #(
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_hi_drop,
  input logic              verdict_valid,
  input logic              verdict_drop,
  input logic [1:0]        verdict_level,
  input logic [LFSR_W-1:0] lfsr_q
);
  a_r9_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> verdict_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !verdict_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_valid |-> (!verdict_drop && verdict_level == 2'd0));

  a_r7_top_level_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_level == 2'd3) |-> verdict_drop);

  a_r8_calm_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_level == 2'd0) |-> !verdict_drop);

  a_r5_low_spared: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_valid && verdict_level == 2'd1 && !$past(req_hi_drop)) |-> !verdict_drop);

  a_r12_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

bind wred_drop_decider wred_drop_checker #(.LFSR_W(LFSR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_hi_drop   (req_hi_drop),
  .verdict_valid (verdict_valid),
  .verdict_drop  (verdict_drop),
  .verdict_level (verdict_level),
  .lfsr_q        (lfsr_q)
);

// File: tb/sim_wred_drop_decider.sv
module sim_wred_drop_decider;
  localparam int CNT_W = 14;
  localparam int THR_W = 8;
  localparam int USH   = 4;

  typedef struct {
    logic [1:0] lvl;
    logic       chk_drop;
    logic       drop;
    logic       stat;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_hi_drop, sched_delay_mode;
  logic [2:0] req_dest;
  logic [6*CNT_W-1:0] q_bytes;
  logic [6*THR_W-1:0] q_thr;
  logic [6:0] pct_x, pct_y, pct_z;
  logic verdict_valid, verdict_drop;
  logic [1:0] verdict_level;

  int checks = 0;
  int failures = 0;
  int stat_drops = 0;
  int stat_seen = 0;
  int cnt [6];
  int thr [6];
  exp_t sb[$];

  always #5 clk = ~clk;

  wred_drop_decider #(.CNT_W(CNT_W), .THR_W(THR_W), .UNIT_SHIFT(USH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .req_hi_drop(req_hi_drop), .sched_delay_mode(sched_delay_mode),
    .q_bytes(q_bytes), .q_thr(q_thr), .pct_x(pct_x), .pct_y(pct_y), .pct_z(pct_z),
    .verdict_valid(verdict_valid), .verdict_drop(verdict_drop),
    .verdict_level(verdict_level)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_counts(input int c0, c1, c2, c3, c4, c5);
    cnt[0] = c0; cnt[1] = c1; cnt[2] = c2; cnt[3] = c3; cnt[4] = c4; cnt[5] = c5;
  endtask

  // driver: called at a negedge, pushes expectation and presents one request
  task automatic send(input logic mode, input logic hi, input int dst,
                      input int elvl, input logic chk, input logic edrop,
                      input logic st, input string tag);
    exp_t e;
    for (int i = 0; i < 6; i++) begin
      q_bytes[i*CNT_W +: CNT_W] = CNT_W'(cnt[i]);
      q_thr[i*THR_W +: THR_W]   = THR_W'(thr[i]);
    end
    sched_delay_mode = mode;
    req_hi_drop = hi;
    req_dest = 3'(dst);
    e.lvl = 2'(elvl); e.chk_drop = chk; e.drop = edrop; e.stat = st; e.tag = tag;
    sb.push_back(e);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops and compares at the negedge after each captured request
  always @(negedge clk) begin
    if (rst_n && verdict_valid) begin
      if (sb.size() == 0) begin
        check("R9 unexpected verdict", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (e.stat) begin
          stat_seen++;
          if (verdict_drop) stat_drops++;
        end else begin
          check({e.tag, " level"}, int'(verdict_level), int'(e.lvl));
          if (e.chk_drop) check({e.tag, " drop"}, int'(verdict_drop), int'(e.drop));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_hi_drop = 1'b0; sched_delay_mode = 1'b0;
    req_dest = 3'd0; q_bytes = '0; q_thr = '0;
    pct_x = 7'd0; pct_y = 7'd0; pct_z = 7'd0;
    for (int i = 0; i < 6; i++) begin cnt[i] = 0; thr[i] = 255; end
    repeat (3) @(negedge clk);
    check("R11 reset valid", int'(verdict_valid), 0);
    check("R11 reset drop", int'(verdict_drop), 0);
    check("R11 reset level", int'(verdict_level), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 delay-bound weights; boundaries at 3840/4480/5120 bytes
    set_counts(0, 0, 0, 0, 0, 240);
    send(1, 0, 0, 1, 1, 0, 0, "R1 P7 x16 at edge1");
    send(0, 0, 0, 0, 1, 0, 0, "R2 same counts equal weights");
    set_counts(0, 0, 0, 0, 0, 239);
    send(1, 0, 0, 0, 1, 0, 0, "R3 one below edge1");
    set_counts(0, 0, 0, 0, 280, 0);
    send(1, 0, 0, 2, 1, 0, 0, "R1 P6 x16 at edge2");
    set_counts(0, 0, 0, 640, 0, 0);
    send(1, 0, 0, 3, 1, 1, 0, "R1 P5 x8 at edge3");
    set_counts(1840, 1000, 0, 0, 0, 0);
    send(1, 0, 0, 1, 1, 0, 0, "R1 P2 x1 plus P3 x2");
    set_counts(0, 0, 1119, 0, 0, 0);
    send(1, 0, 0, 1, 1, 0, 0, "R1 P4 x4 below edge2");
    // R2 equal weights
    set_counts(1000, 1000, 1000, 1000, 1000, 0);
    send(0, 0, 0, 2, 1, 0, 0, "R2 sum 5000");
    set_counts(1000, 1000, 1000, 1000, 1000, 120);
    send(0, 1, 0, 3, 1, 1, 0, "R2 sum at edge3");
    set_counts(1000, 1000, 1000, 839, 0, 0);
    send(0, 0, 0, 0, 1, 0, 0, "R2 sum one below edge1");

    // R4 per-queue threshold on P4 (lane 2) = 10 units = 160 bytes
    thr[2] = 10;
    set_counts(0, 0, 160, 0, 0, 0);
    send(0, 0, 4, 1, 1, 0, 0, "R4 dest P4 at threshold");
    send(0, 0, 5, 0, 1, 0, 0, "R4 other dest unaffected");
    thr[0] = 0; thr[1] = 0;
    send(0, 0, 0, 0, 1, 0, 0, "R4 dest P0 ignored");
    send(0, 0, 1, 0, 1, 0, 0, "R4 dest P1 ignored");
    thr[0] = 255; thr[1] = 255;
    set_counts(0, 0, 159, 0, 0, 0);
    send(0, 0, 4, 0, 1, 0, 0, "R4 dest P4 below threshold");
    set_counts(1000, 1000, 1000, 1000, 500, 0);
    send(0, 0, 4, 2, 1, 0, 0, "R3 highest level wins over queue");
    thr[2] = 255;

    // R5/R6/R7/R8 drop percentages
    pct_x = 7'd100; pct_y = 7'd0; pct_z = 7'd0;
    set_counts(0, 0, 0, 0, 0, 240);
    send(1, 0, 0, 1, 1, 0, 0, "R5 low-drop spared at 100");
    send(1, 1, 0, 1, 1, 1, 0, "R5 high-drop x=100");
    pct_x = 7'd0;
    send(1, 1, 0, 1, 1, 0, 0, "R8 high-drop x=0");
    set_counts(0, 0, 0, 0, 280, 0);
    pct_y = 7'd100;
    send(1, 1, 0, 2, 1, 1, 0, "R6 high-drop y=100");
    send(1, 0, 0, 2, 1, 0, 0, "R6 low-drop z=0");
    pct_z = 7'd100; pct_y = 7'd0;
    send(1, 0, 0, 2, 1, 1, 0, "R6 low-drop z=100");
    send(1, 1, 0, 2, 1, 0, 0, "R6 high-drop y=0");
    pct_z = 7'd127;
    send(1, 0, 0, 2, 1, 1, 0, "R8 pct above 100");
    pct_x = 7'd0; pct_y = 7'd0; pct_z = 7'd0;
    set_counts(0, 0, 0, 640, 0, 0);
    send(1, 0, 0, 3, 1, 1, 0, "R7 low-drop at level three");
    send(1, 1, 0, 3, 1, 1, 0, "R7 high-drop at level three");
    pct_x = 7'd100; pct_y = 7'd100; pct_z = 7'd100;
    set_counts(0, 0, 0, 0, 0, 10);
    send(1, 1, 0, 0, 1, 0, 0, "R8 no drop at level none");

    // R10 full-scale counts
    set_counts(16383, 16383, 16383, 16383, 16383, 16383);
    send(1, 0, 0, 3, 1, 1, 0, "R10 max counts delay-bound");
    send(0, 0, 0, 3, 1, 1, 0, "R10 max counts equal weights");

    // R8 rate at 50 percent
    pct_x = 7'd50;
    set_counts(0, 0, 0, 0, 0, 240);
    for (int k = 0; k < 400; k++) send(1, 1, 0, 1, 0, 0, 1, "R8 stat");
    @(negedge clk);
    checks++;
    if (stat_seen != 400 || stat_drops < 120 || stat_drops > 280) begin
      failures++;
      $display("FAIL R8 drop rate actual=%0d/%0d expected=120..280/400", stat_drops, stat_seen);
    end

    // R9 idle behaviour and drain
    repeat (3) @(negedge clk);
    check("R9 idle valid", int'(verdict_valid), 0);
    check("R9 idle drop", int'(verdict_drop), 0);
    check("R9 scoreboard drained", sb.size(), 0);
    report();
  end
endmodule